// File: doc/BRIEF.md
# SIMT Lane Execution Mask Controller

This block holds the active-lane mask of a 64-lane vector unit and carries out structured control flow by rewriting that mask. Divergence is handled by parking and restoring lanes through AND, OR, XOR and AND-NOT operations on masks, with no hardware reconvergence stack. Each command picks one operation: if, else, end, loop, break, if-break, else-break, per-lane kill, constant kill or skip-test. Every command carries a per-lane condition mask and a saved-mask operand. The saved masks themselves live in scalar registers outside the block and are passed in and out as operands.

The block returns the updated active mask and the value to be written back into a scalar register. It also returns an all-lanes-idle flag that lets the sequencer branch over a region where no lane would do any work. A loop command raises a loop-back pulse while any lane is still running. A skip-test command raises a skip pulse when the mask is empty. All outputs are registered. A command sampled with its valid strobe on one rising edge shows its effect from that edge onward.

Top module: `lane_mask_ctrl`

## Requirements
- R1: In reset, `activeMask` is all ones, `savedOut` is zero, and `execZero`, `loopBack` and `skipTaken` are 0.
- R2: If (code 1): `savedOut` becomes active AND NOT cond, which are the lanes that failed the test. `activeMask` becomes active AND cond.
- R3: Else (code 2): `savedOut` becomes the current active mask. `activeMask` becomes (active OR savedIn) XOR active, so only the parked lanes stay enabled.
- R4: End (code 3): `activeMask` becomes active OR savedIn. `savedOut` is unchanged.
- R5: Loop (code 4): `activeMask` becomes active AND NOT savedIn, where savedIn is the accumulated break mask. `loopBack` is 1 for one cycle exactly when that result is non-zero.
- R6: Break (code 5) sets `savedOut` to active OR savedIn. If-break (code 6) and else-break (code 7) set `savedOut` to condMask OR savedIn; for else-break, condMask carries the else-saved mask. None of the three changes `activeMask`.
- R7: Per-lane kill (code 8): each bit of condMask is the sign bit of that lane's value. A lane stays active only if its bit is 0, that is, only if its value is at least zero.
- R8: Constant kill (code 9): when `constSign` is 1 the whole mask is cleared; when it is 0 the mask is unchanged.
- R9: `execZero` is 1 exactly when `activeMask` is all zero. Skip-test (code 10) leaves the mask unchanged and pulses `skipTaken` for one cycle when the mask is all zero.
- R10: With `cmdValid` low, or with an unused code (0, 11 to 15), `activeMask` and `savedOut` hold and both pulses stay 0. Updates appear on the cycle after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command strobe |
| cmdOp | input | 4 | Command code |
| condMask | input | 64 | Per-lane condition, sign bits, or else-saved mask |
| savedIn | input | 64 | Saved or break mask operand |
| constSign | input | 1 | Sign bit of the constant kill operand |
| activeMask | output | 64 | Current active-lane mask |
| savedOut | output | 64 | Value to store into a scalar register |
| execZero | output | 1 | Active mask is all zero |
| loopBack | output | 1 | Loop should iterate again (pulse) |
| skipTaken | output | 1 | Skip-test found no live lane (pulse) |

## Verification
Every result is due exactly one rising edge after the command is sampled. This covers the new mask, the saved value, the idle flag and both pulses. The bench drives inputs on falling edges and compares all five outputs on the next falling edge against a model stepped once per command. Random commands, condition masks and idle gaps are mixed with directed cases for reset, constant kill, an empty-mask skip and a loop that retires every lane.

// File: rtl/lane_mask_pkg.sv
package lane_mask_pkg;
  typedef enum logic [3:0] {
    OP_NOP      = 4'd0,
    OP_IF       = 4'd1,
    OP_ELSE     = 4'd2,
    OP_END      = 4'd3,
    OP_LOOP     = 4'd4,
    OP_BRK      = 4'd5,
    OP_IFBRK    = 4'd6,
    OP_ELSEBRK  = 4'd7,
    OP_KILLV    = 4'd8,
    OP_KILLC    = 4'd9,
    OP_SKIP     = 4'd10
  } maskOp_e;

  typedef enum logic [2:0] {
    MS_AND_COND,
    MS_ELSE_SWAP,
    MS_OR_SAVED,
    MS_ANDN_SAVED,
    MS_ANDN_COND,
    MS_CLEAR
  } maskSel_e;

  typedef enum logic [1:0] {
    SS_PARKED,
    SS_ACTIVE,
    SS_ACT_OR_IN,
    SS_COND_OR_IN
  } savedSel_e;

  typedef struct packed {
    logic      ldMask;
    maskSel_e  maskSel;
    logic      ldSaved;
    savedSel_e savedSel;
    logic      loopChk;
    logic      skipChk;
  } maskStrobes_t;
endpackage

// File: rtl/lane_mask_decode.sv
module lane_mask_decode
  import lane_mask_pkg::*;
(
  input  logic         cmdValid,
  input  logic [3:0]   cmdOp,
  input  logic         constSign,
  output maskStrobes_t strobes
);
  always_comb begin
    strobes = '{ldMask: 1'b0, maskSel: MS_AND_COND, ldSaved: 1'b0,
                savedSel: SS_PARKED, loopChk: 1'b0, skipChk: 1'b0};
    if (cmdValid) begin
      case (maskOp_e'(cmdOp))
        OP_IF: begin
          strobes.ldMask   = 1'b1;
          strobes.maskSel  = MS_AND_COND;
          strobes.ldSaved  = 1'b1;
          strobes.savedSel = SS_PARKED;
        end
        OP_ELSE: begin
          strobes.ldMask   = 1'b1;
          strobes.maskSel  = MS_ELSE_SWAP;
          strobes.ldSaved  = 1'b1;
          strobes.savedSel = SS_ACTIVE;
        end
        OP_END: begin
          strobes.ldMask  = 1'b1;
          strobes.maskSel = MS_OR_SAVED;
        end
        OP_LOOP: begin
          strobes.ldMask  = 1'b1;
          strobes.maskSel = MS_ANDN_SAVED;
          strobes.loopChk = 1'b1;
        end
        OP_BRK: begin
          strobes.ldSaved  = 1'b1;
          strobes.savedSel = SS_ACT_OR_IN;
        end
        OP_IFBRK, OP_ELSEBRK: begin
          strobes.ldSaved  = 1'b1;
          strobes.savedSel = SS_COND_OR_IN;
        end
        OP_KILLV: begin
          strobes.ldMask  = 1'b1;
          strobes.maskSel = MS_ANDN_COND;
        end
        OP_KILLC: begin
          strobes.ldMask  = constSign;
          strobes.maskSel = MS_CLEAR;
        end
        OP_SKIP: strobes.skipChk = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/lane_mask_datapath.sv
module lane_mask_datapath
  import lane_mask_pkg::*;
#(
  parameter int LANES = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  maskStrobes_t       strobes,
  input  logic [LANES-1:0]   condMask,
  input  logic [LANES-1:0]   savedIn,
  output logic [LANES-1:0]   activeMask,
  output logic [LANES-1:0]   savedOut,
  output logic               execZero,
  output logic               loopBack,
  output logic               skipTaken
);
  localparam logic [LANES-1:0] ALL_ON = {LANES{1'b1}};

  logic [LANES-1:0] maskNext;
  logic [LANES-1:0] savedNext;

  always_comb begin
    case (strobes.maskSel)
      MS_AND_COND:   maskNext = activeMask & condMask;
      MS_ELSE_SWAP:  maskNext = (activeMask | savedIn) ^ activeMask;
      MS_OR_SAVED:   maskNext = activeMask | savedIn;
      MS_ANDN_SAVED: maskNext = activeMask & ~savedIn;
      MS_ANDN_COND:  maskNext = activeMask & ~condMask;
      default:       maskNext = '0;
    endcase
    if (!strobes.ldMask) maskNext = activeMask;
  end

  always_comb begin
    case (strobes.savedSel)
      SS_PARKED:    savedNext = activeMask ^ (activeMask & condMask);
      SS_ACTIVE:    savedNext = activeMask;
      SS_ACT_OR_IN: savedNext = activeMask | savedIn;
      default:      savedNext = condMask | savedIn;
    endcase
    if (!strobes.ldSaved) savedNext = savedOut;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeMask <= ALL_ON;
      savedOut   <= '0;
      execZero   <= 1'b0;
      loopBack   <= 1'b0;
      skipTaken  <= 1'b0;
    end else begin
      activeMask <= maskNext;
      savedOut   <= savedNext;
      execZero   <= (maskNext == '0);
      loopBack   <= strobes.loopChk && (maskNext != '0);
      skipTaken  <= strobes.skipChk && (activeMask == '0);
    end
  end
endmodule

// File: rtl/lane_mask_ctrl.sv
module lane_mask_ctrl
  import lane_mask_pkg::*;
#(
  parameter int LANES = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [3:0]       cmdOp,
  input  logic [LANES-1:0] condMask,
  input  logic [LANES-1:0] savedIn,
  input  logic             constSign,
  output logic [LANES-1:0] activeMask,
  output logic [LANES-1:0] savedOut,
  output logic             execZero,
  output logic             loopBack,
  output logic             skipTaken
);
  maskStrobes_t strobes;

  lane_mask_decode decode_i (
    .cmdValid (cmdValid),
    .cmdOp    (cmdOp),
    .constSign(constSign),
    .strobes  (strobes)
  );

  lane_mask_datapath #(.LANES(LANES)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .condMask  (condMask),
    .savedIn   (savedIn),
    .activeMask(activeMask),
    .savedOut  (savedOut),
    .execZero  (execZero),
    .loopBack  (loopBack),
    .skipTaken (skipTaken)
  );
endmodule

// File: rtl/lane_mask_ctrl_chk.sv
module lane_mask_ctrl_chk #(
  parameter int LANES = 64
) (
  input logic             clk,
  input logic             rstN,
  input logic             cmdValid,
  input logic [3:0]       cmdOp,
  input logic [LANES-1:0] condMask,
  input logic [LANES-1:0] savedIn,
  input logic             constSign,
  input logic [LANES-1:0] activeMask,
  input logic [LANES-1:0] savedOut,
  input logic             execZero,
  input logic             loopBack,
  input logic             skipTaken
);
  AST_IF_NARROWS: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == 4'd1) |=> activeMask == ($past(activeMask) & $past(condMask))); // R2
  AST_END_WIDENS: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == 4'd3) |=> (activeMask & $past(activeMask)) == $past(activeMask)); // R4
  AST_LOOP_LIVE: assert property (@(posedge clk) disable iff (!rstN)
    loopBack |-> activeMask != '0); // R5
  AST_KILL_SHRINKS: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == 4'd8) |=> (activeMask & ~$past(activeMask)) == '0); // R7
  AST_KILLC_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == 4'd9 && constSign) |=> activeMask == '0); // R8
  AST_EXECZ_TRACKS: assert property (@(posedge clk) disable iff (!rstN)
    execZero == (activeMask == '0)); // R9
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !cmdValid |=> $stable(activeMask) && $stable(savedOut) && !loopBack && !skipTaken); // R10
endmodule

bind lane_mask_ctrl lane_mask_ctrl_chk #(.LANES(LANES)) chk_i (.*);

// File: tb/lane_mask_ctrl_tb.sv
module lane_mask_ctrl_tb_top;
  localparam int LANES = 64;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [3:0] cmdOp = '0;
  logic [LANES-1:0] condMask = '0, savedIn = '0;
  logic constSign = 1'b0;
  logic [LANES-1:0] activeMask, savedOut;
  logic execZero, loopBack, skipTaken;

  int checks = 0, errors = 0;
  logic [LANES-1:0] refMask, refSaved;

  always #2.5 clk = ~clk;

  lane_mask_ctrl #(.LANES(LANES)) dut_i (.*);

  function automatic string reqOf(input logic [3:0] op);
    case (op)
      4'd1: return "R2";   4'd2: return "R3";   4'd3: return "R4";
      4'd4: return "R5";   4'd5, 4'd6, 4'd7: return "R6";
      4'd8: return "R7";   4'd9: return "R8";   4'd10: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [LANES-1:0] got, input logic [LANES-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic step(input logic v, input logic [3:0] op, input logic [LANES-1:0] c,
                      input logic [LANES-1:0] s, input logic k);
    logic [LANES-1:0] m, sv;
    logic lb, sk;
    string rq;
    cmdValid = v; cmdOp = op; condMask = c; savedIn = s; constSign = k;
    m = refMask; sv = refSaved; lb = 1'b0; sk = 1'b0;
    rq = v ? reqOf(op) : "R10";
    if (v) begin
      case (op)
        4'd1: begin sv = refMask & ~c; m = refMask & c; end
        4'd2: begin sv = refMask; m = s & ~refMask; end
        4'd3: m = refMask | s;
        4'd4: begin m = refMask & ~s; lb = (m != '0); end
        4'd5: sv = refMask | s;
        4'd6, 4'd7: sv = c | s;
        4'd8: m = refMask & ~c;
        4'd9: if (k) m = '0;
        4'd10: sk = (refMask == '0);
        default: ;
      endcase
    end
    @(negedge clk);
    check(rq, "activeMask", activeMask, m);
    check(rq, "savedOut", savedOut, sv);
    check("R9", "execZero", {63'd0, execZero}, {63'd0, m == '0});
    check(rq, "loopBack", {63'd0, loopBack}, {63'd0, lb});
    check(rq, "skipTaken", {63'd0, skipTaken}, {63'd0, sk});
    refMask = m; refSaved = sv;
  endtask

  function automatic logic [LANES-1:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    refMask = '1; refSaved = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "activeMask", activeMask, '1);
    check("R1", "savedOut", savedOut, '0);
    check("R1", "flags", {61'd0, execZero, loopBack, skipTaken}, '0);
    rstN = 1'b1;
    @(negedge clk);
    // directed corner cases
    step(1'b1, 4'd9, '0, '0, 1'b0);                       // R8 no sign: no change
    step(1'b1, 4'd1, 64'h0000_FFFF_0000_FFFF, '0, 1'b0);  // R2
    step(1'b1, 4'd2, '0, refSaved, 1'b0);                 // R3
    step(1'b1, 4'd3, '0, '1, 1'b0);                       // R4 restore all
    step(1'b1, 4'd8, 64'h8000_0000_0000_0001, '0, 1'b0);  // R7
    step(1'b1, 4'd4, '0, refMask, 1'b0);                  // R5 loop retires all lanes
    step(1'b1, 4'd10, '0, '0, 1'b0);                      // R9 skip on empty mask
    step(1'b1, 4'd3, '0, '1, 1'b0);
    step(1'b1, 4'd10, '0, '0, 1'b0);                      // R9 skip on live mask
    step(1'b1, 4'd9, '0, '0, 1'b1);                       // R8 sign set: clear
    step(1'b1, 4'd12, rnd64(), rnd64(), 1'b1);            // R10 unused code
    step(1'b0, 4'd3, '0, '1, 1'b0);                       // R10 no strobe
    step(1'b1, 4'd3, '0, '1, 1'b0);
    step(1'b1, 4'd4, '0, 64'h1, 1'b0);                    // R5 loop continues
    step(1'b1, 4'd5, '0, 64'hF0, 1'b0);                   // R6 break
    step(1'b1, 4'd6, 64'h3, 64'h30, 1'b0);                // R6 if-break
    step(1'b1, 4'd7, 64'h5, 64'h50, 1'b0);                // R6 else-break
    // constrained random
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] op;
      logic v;
      v  = ($urandom_range(0, 7) != 0);
      op = 4'($urandom_range(0, 15));
      if ($urandom_range(0, 5) == 0) op = 4'd3;
      step(v, op, rnd64() | rnd64(), ($urandom_range(0, 3) == 0) ? '1 : rnd64(),
           1'($urandom_range(0, 1)));
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule